// File: doc/BRIEF.md
# 2:4 Structured-Sparsity Group Compressor

The block takes a dense row of 16-bit elements as a stream of groups of four adjacent elements. For each group it keeps two values and records where they came from as two 2-bit positions. The kept pair goes out on a value stream. The positions form a 4-bit nibble, and four nibbles are packed little-endian into a 16-bit metadata word, which goes out on a separate stream. Groups with fewer than two non-zero elements still produce a legal position pair. Groups with more than two non-zero elements are flagged by a sticky violation output.

The input handshake stalls whenever either output register holds a beat that is not being taken in the same cycle. The value beat for a group appears on the cycle after the group is accepted. A metadata word appears on the cycle after its fourth group is accepted, or after the group marked as row end, whichever comes first.

Top module: `sp24_compressor`

## Requirements
- R1: An element counts as zero when its low 15 bits are all zero, so 0x8000 (negative zero) is treated as zero and is never kept.
- R2: With two or more non-zero elements, the first two in ascending position are kept. The earlier one goes to slot 0 (val_data[15:0]) and the later one to slot 1 (val_data[31:16]). The nibble holds the first position in bits [1:0] and the second in bits [3:2].
- R3: When the only non-zero element sits at position 0, 1 or 2, the positions are (that position, 3). Slot 0 carries the value and slot 1 is zero.
- R4: When the only non-zero element sits at position 3, the positions are (0, 3). Slot 0 is zero and slot 1 carries the value.
- R5: An all-zero group gives positions (0, 1), which is nibble 0b0100, and both slots are zero.
- R6: Group g (0..3) of a metadata word occupies bits [4g+3:4g]. A word is emitted once its fourth group is accepted. For example, groups [0,7,0,3], [1,5,0,0], [0,0,2,4], [9,0,9,0] give the word 0x8E4D.
- R7: Accepting a group with in_last set emits the partial word at once. The unused higher nibbles are filled with 0b0100, and the next group starts a new word at nibble 0.
- R8: A group with three or four non-zero elements sets viol_flag on the cycle after it is accepted. The flag then stays set until reset.
- R9: in_ready is high exactly when each output register is empty or is handing off its beat in the same cycle. While an output is valid and not taken, its valid and data hold steady.
- R10: During and right after reset, val_valid, meta_valid and viol_flag are low and the nibble position restarts at 0.
- R11: An accepted group's value beat is valid on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Input group accepted when high with in_valid |
| in_group | input | 64 | Four elements; element i at bits [16i+15:16i] |
| in_last | input | 1 | Group is the last of its row (flush partial word) |
| val_valid | output | 1 | Kept-value pair valid |
| val_ready | input | 1 | Consumer takes the value pair |
| val_data | output | 32 | Slot 1 in [31:16], slot 0 in [15:0] |
| meta_valid | output | 1 | Metadata word valid |
| meta_ready | input | 1 | Consumer takes the metadata word |
| meta_word | output | 16 | Four packed position nibbles |
| viol_flag | output | 1 | Sticky 2:4 pattern violation |

## Verification
Three events can land on the same clock edge: a word completion, a row-end flush and a value beat. The hardest case is when a fourth group also carries in_last, so the full-word rule and the flush rule must agree, while backpressure on one output stalls the input. The bench provokes this with directed rows of one to four groups plus long random runs that toggle both ready inputs independently. A behavioural model checks every value pair and metadata word in order, and checks in_ready and output hold behaviour on every clock.

// File: rtl/sp24_pkg.sv
package sp24_pkg;
  typedef logic [1:0] pos_t;

  localparam logic [3:0] PAD_NIBBLE = 4'b0100;

  // Build a nibble from the two kept positions (first in the low pair).
  function automatic logic [3:0] make_nibble(input pos_t first_pos, input pos_t second_pos);
    return {second_pos, first_pos};
  endfunction

  // A nibble is legal when the second position is strictly above the first.
  function automatic logic nibble_ordered(input logic [3:0] nib);
    return nib[3:2] > nib[1:0];
  endfunction
endpackage

// File: rtl/sp24_group_reduce.sv
module sp24_group_reduce
  import sp24_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int GRP_N  = 4
) (
  input  logic [GRP_N*ELEM_W-1:0] grp,
  output pos_t                    first_pos,
  output pos_t                    second_pos,
  output logic [ELEM_W-1:0]       keep0,
  output logic [ELEM_W-1:0]       keep1,
  output logic                    over_dense
);
  localparam int CNT_W = $clog2(GRP_N + 1);

  logic [GRP_N-1:0] nz;

  // Magnitude bits only: the sign bit does not make a value non-zero.
  for (genvar i = 0; i < GRP_N; i++) begin : g_nz
    assign nz[i] = |grp[i*ELEM_W +: ELEM_W-1];
  end

  pos_t             pa, pb;
  logic             seen_a, seen_b;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    pa = '0; pb = '0; seen_a = 1'b0; seen_b = 1'b0; cnt = '0;
    for (int i = 0; i < GRP_N; i++) begin
      if (nz[i]) begin
        if (!seen_a) begin
          pa = pos_t'(i); seen_a = 1'b1;
        end else if (!seen_b) begin
          pb = pos_t'(i); seen_b = 1'b1;
        end
        cnt = cnt + 1'b1;
      end
    end
  end

  always_comb begin
    first_pos  = pa;
    second_pos = pb;
    keep0      = grp[pa*ELEM_W +: ELEM_W];
    keep1      = grp[pb*ELEM_W +: ELEM_W];
    over_dense = (cnt > CNT_W'(2));
    if (!seen_a) begin
      first_pos  = pos_t'(0);
      second_pos = pos_t'(1);
      keep0      = '0;
      keep1      = '0;
    end else if (!seen_b) begin
      if (pa == pos_t'(GRP_N-1)) begin
        first_pos  = pos_t'(0);
        second_pos = pos_t'(GRP_N-1);
        keep1      = grp[pa*ELEM_W +: ELEM_W];
        keep0      = '0;
      end else begin
        second_pos = pos_t'(GRP_N-1);
        keep1      = '0;
      end
    end
  end
endmodule

// File: rtl/sp24_meta_packer.sv
module sp24_meta_packer
  import sp24_pkg::*;
#(
  parameter int NIB_PER_WORD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      row_end,
  input  logic [3:0]                nib,
  input  logic                      take,
  output logic                      word_emit,
  output logic                      word_valid,
  output logic [4*NIB_PER_WORD-1:0] word
);
  localparam int SLOT_W = (NIB_PER_WORD > 1) ? $clog2(NIB_PER_WORD) : 1;
  localparam int WORD_W = 4 * NIB_PER_WORD;

  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;

  // Older nibbles from the accumulator, the new one at its slot, padding above.
  for (genvar g = 0; g < NIB_PER_WORD; g++) begin : g_merge
    assign merged[4*g +: 4] = (SLOT_W'(g) < slot)  ? acc[4*g +: 4] :
                              (SLOT_W'(g) == slot) ? nib : PAD_NIBBLE;
  end

  assign word_emit = push && (row_end || slot == SLOT_W'(NIB_PER_WORD-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= '0;
      acc        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      if (word_emit) begin
        word       <= merged;
        word_valid <= 1'b1;
        acc        <= '0;
        slot       <= '0;
      end else begin
        if (push) begin
          acc  <= merged;
          slot <= slot + 1'b1;
        end
        if (take) word_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sp24_val_stage.sv
module sp24_val_stage #(
  parameter int ELEM_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ELEM_W-1:0]   slot0,
  input  logic [ELEM_W-1:0]   slot1,
  input  logic                take,
  output logic                pair_valid,
  output logic [2*ELEM_W-1:0] pair
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_valid <= 1'b0;
      pair       <= '0;
    end else if (load) begin
      pair_valid <= 1'b1;
      pair       <= {slot1, slot0};
    end else if (take) begin
      pair_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sp24_compressor.sv
module sp24_compressor
  import sp24_pkg::*;
#(
  parameter int ELEM_W       = 16,
  parameter int NIB_PER_WORD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [4*ELEM_W-1:0]       in_group,
  input  logic                      in_last,
  output logic                      val_valid,
  input  logic                      val_ready,
  output logic [2*ELEM_W-1:0]       val_data,
  output logic                      meta_valid,
  input  logic                      meta_ready,
  output logic [4*NIB_PER_WORD-1:0] meta_word,
  output logic                      viol_flag
);
  localparam int GRP_N = 4;

  pos_t              pos_a, pos_b;
  logic [ELEM_W-1:0] kv0, kv1;
  logic              grp_viol;
  logic              accept;
  logic              word_emit;
  logic              val_free, meta_free;

  assign val_free  = !val_valid  || val_ready;
  assign meta_free = !meta_valid || meta_ready;
  assign in_ready  = val_free && meta_free;
  assign accept    = in_valid && in_ready;

  sp24_group_reduce #(.ELEM_W(ELEM_W), .GRP_N(GRP_N)) u_reduce (
    .grp        (in_group),
    .first_pos  (pos_a),
    .second_pos (pos_b),
    .keep0      (kv0),
    .keep1      (kv1),
    .over_dense (grp_viol)
  );

  sp24_val_stage #(.ELEM_W(ELEM_W)) u_vals (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .slot0      (kv0),
    .slot1      (kv1),
    .take       (val_ready),
    .pair_valid (val_valid),
    .pair       (val_data)
  );

  sp24_meta_packer #(.NIB_PER_WORD(NIB_PER_WORD)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .row_end    (in_last),
    .nib        (make_nibble(pos_a, pos_b)),
    .take       (meta_ready),
    .word_emit  (word_emit),
    .word_valid (meta_valid),
    .word       (meta_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) viol_flag <= 1'b0;
    else if (accept && grp_viol) viol_flag <= 1'b1;
  end
endmodule

// File: rtl/sp24_compressor_chk.sv
module sp24_compressor_chk
  import sp24_pkg::*;
#(
  parameter int ELEM_W       = 16,
  parameter int NIB_PER_WORD = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      in_last,
  input logic                      accept,
  input logic                      grp_viol,
  input logic                      word_emit,
  input logic                      val_valid,
  input logic                      val_ready,
  input logic [2*ELEM_W-1:0]       val_data,
  input logic                      meta_valid,
  input logic                      meta_ready,
  input logic [4*NIB_PER_WORD-1:0] meta_word,
  input logic                      viol_flag
);
  function automatic logic word_legal(input logic [4*NIB_PER_WORD-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int g = 0; g < NIB_PER_WORD; g++) ok = ok && nibble_ordered(w[4*g +: 4]);
    return ok;
  endfunction

  p_val_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val_valid && !val_ready |=> val_valid && $stable(val_data));

  p_meta_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    meta_valid && !meta_ready |=> meta_valid && $stable(meta_word));

  p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (val_valid && !val_ready) || (meta_valid && !meta_ready) |-> !in_ready);

  p_pair_next_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> val_valid);

  p_flush_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_last |=> meta_valid);

  p_emit_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_emit |=> meta_valid);

  p_viol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && grp_viol |=> viol_flag);

  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> viol_flag);

  p_nibbles_ordered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meta_valid |-> word_legal(meta_word));
endmodule

bind sp24_compressor sp24_compressor_chk #(.ELEM_W(ELEM_W), .NIB_PER_WORD(NIB_PER_WORD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .accept     (accept),
  .grp_viol   (grp_viol),
  .word_emit  (word_emit),
  .val_valid  (val_valid),
  .val_ready  (val_ready),
  .val_data   (val_data),
  .meta_valid (meta_valid),
  .meta_ready (meta_ready),
  .meta_word  (meta_word),
  .viol_flag  (viol_flag)
);

// File: tb/sp24_compressor_bench.sv
module sp24_compressor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_group = '0;
  logic        in_last = 1'b0;
  logic        val_valid;
  logic        val_ready = 1'b1;
  logic [31:0] val_data;
  logic        meta_valid;
  logic        meta_ready = 1'b1;
  logic [15:0] meta_word;
  logic        viol_flag;

  always #2.5 clk = ~clk;

  sp24_compressor u_sp24_compressor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_group(in_group), .in_last(in_last), .val_valid(val_valid),
    .val_ready(val_ready), .val_data(val_data), .meta_valid(meta_valid),
    .meta_ready(meta_ready), .meta_word(meta_word), .viol_flag(viol_flag)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit bp_mode = 1'b0;
  bit acc_now = 1'b0;
  bit finished = 1'b0;

  logic [31:0] pair_q[$];
  string       pair_tag_q[$];
  logic [15:0] word_q[$];
  string       word_tag_q[$];
  logic [15:0] mw = '0;
  int          mslot = 0;
  int          words_seen = 0;
  bit          exp_viol = 1'b0;
  bit          prev_acc = 1'b0;
  bit          prev_vstall = 1'b0, prev_mstall = 1'b0;
  logic [31:0] prev_vdata;
  logic [15:0] prev_mword;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference reduction written from the requirements.
  task automatic ref_group(input logic [63:0] g, output logic [1:0] a, output logic [1:0] b,
                           output logic [15:0] v0, output logic [15:0] v1,
                           output bit viol, output string tag);
    int pos[$];
    bit negz;
    negz = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (g[16*i +: 15] != 0) pos.push_back(i);
      else if (g[16*i +: 16] == 16'h8000) negz = 1'b1;
    end
    viol = pos.size() > 2;
    if (pos.size() == 0) begin
      a = 0; b = 1; v0 = 0; v1 = 0; tag = "R5";
    end else if (pos.size() == 1 && pos[0] == 3) begin
      a = 0; b = 3; v0 = 0; v1 = g[48 +: 16]; tag = "R4";
    end else if (pos.size() == 1) begin
      a = 2'(pos[0]); b = 3; v0 = g[16*pos[0] +: 16]; v1 = 0; tag = "R3";
    end else begin
      a = 2'(pos[0]); b = 2'(pos[1]);
      v0 = g[16*pos[0] +: 16]; v1 = g[16*pos[1] +: 16]; tag = "R2";
    end
    if (negz) tag = {tag, " R1"};
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_vstall)
        chk(val_valid && val_data == prev_vdata, "R9", "value hold", val_data, prev_vdata);
      if (prev_mstall)
        chk(meta_valid && meta_word == prev_mword, "R9", "meta hold", {16'h0, meta_word}, {16'h0, prev_mword});
      if (prev_acc) chk(val_valid, "R11", "pair valid after accept", 32'(val_valid), 32'd1);
      chk(viol_flag == exp_viol, "R8", "viol_flag", 32'(viol_flag), 32'(exp_viol));
      chk(in_ready == ((!val_valid || val_ready) && (!meta_valid || meta_ready)),
          "R9", "in_ready", 32'(in_ready), 32'((!val_valid || val_ready) && (!meta_valid || meta_ready)));
      if (val_valid && val_ready) begin
        if (pair_q.size() == 0) chk(1'b0, "R11", "unexpected pair", val_data, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = pair_q.pop_front();
          t = pair_tag_q.pop_front();
          chk(val_data == e, t, "pair", val_data, e);
        end
      end
      if (meta_valid && meta_ready) begin
        if (word_q.size() == 0) chk(1'b0, "R6", "unexpected word", {16'h0, meta_word}, 32'h0);
        else begin
          logic [15:0] e;
          string t;
          e = word_q.pop_front();
          t = word_tag_q.pop_front();
          chk(meta_word == e, t, "word", {16'h0, meta_word}, {16'h0, e});
          if (words_seen == 0)
            chk(meta_word == 16'h8E4D, "R6", "worked example", {16'h0, meta_word}, 32'h8E4D);
          words_seen++;
        end
      end
      acc_now = in_valid && in_ready;
      if (acc_now) begin
        logic [1:0] a, b;
        logic [15:0] v0, v1;
        bit viol;
        string tag;
        ref_group(in_group, a, b, v0, v1, viol, tag);
        pair_q.push_back({v1, v0});
        pair_tag_q.push_back(tag);
        mw[4*mslot +: 4] = {b, a};
        mslot++;
        if (mslot == 4 || in_last) begin
          for (int k = mslot; k < 4; k++) mw[4*k +: 4] = 4'b0100;
          word_q.push_back(mw);
          word_tag_q.push_back(mslot < 4 ? "R7" : "R6");
          mw = '0;
          mslot = 0;
        end
        if (viol) exp_viol = 1'b1;
      end
      prev_acc    = acc_now;
      prev_vstall = val_valid && !val_ready;
      prev_mstall = meta_valid && !meta_ready;
      prev_vdata  = val_data;
      prev_mword  = meta_word;
    end
  end

  task automatic send(input logic [63:0] g, input bit last);
    in_valid = 1'b1;
    in_group = g;
    in_last  = last;
    do @(posedge clk); while (!acc_now);
    #1;
    in_valid = 1'b0;
    if (bp_mode && ($urandom % 5 == 0)) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [63:0] grp4(input logic [15:0] e0, e1, e2, e3);
    return {e3, e2, e1, e0};
  endfunction

  function automatic logic [15:0] rand_elem();
    int r;
    r = $urandom % 8;
    if (r < 4) return 16'h0000;
    if (r == 4) return 16'h8000;
    return 16'(($urandom % 16'h7FFF) + 1) | (16'($urandom % 2) << 15);
  endfunction

  initial begin : ready_drive
    forever begin
      @(posedge clk); #1;
      val_ready  = bp_mode ? ($urandom % 3 != 0) : 1'b1;
      meta_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!val_valid && !meta_valid && !viol_flag, "R10", "reset outputs",
        {29'h0, val_valid, meta_valid, viol_flag}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R6: worked example
    send(grp4(0, 7, 0, 3), 0);
    send(grp4(1, 5, 0, 0), 0);
    send(grp4(0, 0, 2, 4), 0);
    send(grp4(9, 0, 9, 0), 0);
    // R1 + R4: negative zeros around a lone value at position 3
    send(grp4(16'h8000, 0, 16'h8000, 16'h1234), 0);
    // R3: lone value at positions 0, 1, 2
    send(grp4(16'h0011, 0, 0, 0), 0);
    send(grp4(0, 16'h8022, 0, 16'h8000), 0);
    send(grp4(0, 0, 16'h0033, 0), 0);
    // R5: all zero, then R7 flush after one group
    send(grp4(0, 0, 0, 0), 0);
    send(grp4(0, 0, 16'h0044, 16'h0055), 1);
    // R7: two- and three-group rows
    send(grp4(16'h0101, 16'h0202, 0, 0), 0);
    send(grp4(0, 16'h0303, 0, 16'h0404), 1);
    send(grp4(0, 0, 0, 0), 0);
    send(grp4(16'h8000, 16'h8000, 16'h8000, 16'h8000), 0);
    send(grp4(16'h0505, 0, 0, 16'h0606), 1);
    // R6 + R7 together: fourth group also marks row end
    send(grp4(1, 2, 0, 0), 0);
    send(grp4(0, 3, 4, 0), 0);
    send(grp4(0, 0, 5, 6), 0);
    send(grp4(7, 0, 0, 8), 1);
    // R8: over-dense group
    send(grp4(16'h0A0A, 16'h0B0B, 16'h0C0C, 0), 1);
    send(grp4(0, 0, 0, 0), 1);
    // Random traffic with backpressure
    bp_mode = 1'b1;
    for (int n = 0; n < 3000; n++)
      send(grp4(rand_elem(), rand_elem(), rand_elem(), rand_elem()), ($urandom % 7) == 0);
    send(grp4(0, 0, 0, 0), 1);
    bp_mode = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(pair_q.size() == 0 && word_q.size() == 0, "R6", "all outputs drained",
        32'(pair_q.size() + word_q.size()), 32'h0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule